// File: doc/BRIEF.md
# TLB Maintenance Register Front End

This block is the control-register window through which privileged software installs and inspects translation entries. It holds three 32-bit registers: an access register carrying a page frame number and permission flags, a control register carrying the way selector, process identifier and two command bits, and a page-entry address register whose middle field names the virtual page. Writing these registers can, as a side effect, store one entry into an internal tag/data array or load one entry back out of it. The array is organised as `WAYS` ways of `SETS` sets, and the set is taken from the low bits of the virtual page number.

Each register has two views. The written view holds what software last stored and is used to form new entries. The read-back view is what software sees, and entry loads update it. Entry stores advance the way selector on their own, so a run of stores fills consecutive ways without software rewriting the selector. A change of process identifier raises a one-cycle event that carries the identifier being left, so that translation caches elsewhere can drop its mappings.

Top module: `tlb_maint_regs`

## Requirements
- R1: After reset every register reads zero, `pid_chg_o` is low, and every entry loads back as all zeros with its valid view bit (control bit 10) clear.
- R2: An access-register write while control bit 1 (store enable) is clear changes no entry, and it does not move the way selector.
- R3: An access-register write while control bit 1 is set stores an entry in way `control[31:28] mod WAYS` and set `vpn mod SETS`. The entry takes its VPN from bits [21:2] of the last written address value, its PID from bits [9:2] of the last written control value, and its global flag from access bit 24.
- R4: A stored entry is valid only when its VPN is below 0xC0000. A load copies the valid flag into control read-back bit 10.
- R5: An entry keeps access bits [23:0] (PFN in [19:0]; cacheable, read, write and execute in 20, 21, 22 and 23) and drops access bits [31:25].
- R6: After every entry store, the way selector in control read-back bits [31:28] becomes (way+1) mod WAYS.
- R7: An access-register write never changes the access read-back value.
- R8: A control write with bit 0 set loads way `wdata[31:28] mod WAYS` at the set given by the written address VPN. Access read-back becomes its own bits [31:25] followed by the entry's global flag in bit 24 and its data in [23:0]. Control read-back becomes the written value with the entry PID in [9:2] and the entry valid flag in bit 10. Address read-back bits [21:2] become the entry VPN.
- R9: An address-register write updates every read-back bit except [21:2], which keep their previous value.
- R10: A control write whose bits [9:2] differ from the last written PID pulses `pid_chg_o` in the next cycle, with `pid_old_o` holding the previous written PID. A write that keeps the PID raises no pulse.
- R11: A control write with bit 0 clear sets the control read-back to exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select: 0 access, 1 control, 2 page-entry address, 3 none |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read-back of the selected register |
| pid_chg_o | output | 1 | One-cycle pulse after a PID change |
| pid_old_o | output | PID_W | Identifier that was replaced |

## Verification
The bench builds the block with its defaults: four ways, sixteen sets, 8-bit PID and the 0xC0000 valid limit. With four ways, four consecutive stores wrap the selector back to zero. With sixteen sets, pages that differ only in their upper bits land on the same set in different ways, so a load must pick the right way. The limit lets one address write produce an invalid entry. Directed writes set up the cases where the written and read-back views diverge, such as a store after a load that changed the PID or VPN read-back. A long pseudo-random mix of writes to all three registers then follows.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned PFN_W  = 20;

  // access register
  localparam int unsigned ACC_G      = 24;
  localparam int unsigned ACC_DATA_W = 24;

  // control register
  localparam int unsigned CTL_RD      = 0;
  localparam int unsigned CTL_WE      = 1;
  localparam int unsigned CTL_PID_LSB = 2;
  localparam int unsigned CTL_VLD     = 10;
  localparam int unsigned CTL_WAY_LSB = 28;
  localparam int unsigned CTL_WAY_FW  = 4;

  // page-entry address register
  localparam int unsigned PTE_VPN_LSB = 2;

  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_PTE  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             x;
    logic             w;
    logic             r;
    logic             c;
    logic [PFN_W-1:0] pfn;
  } ent_data_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic             g;
    logic             vld;
  } ent_hi_t;
endpackage

// File: rtl/tlb_entry_codec.sv
module tlb_entry_codec
  import tlb_maint_pkg::*;
#(
  parameter logic [VPN_W-1:0] VLD_LIMIT = 20'hC0000
) (
  input  logic [ACC_G:0]         acc_bits_i,
  input  logic [VPN_W-1:0]       vpn_i,
  output ent_hi_t                new_hi_o,
  output ent_data_t              new_data_o,
  input  ent_hi_t                rd_hi_i,
  input  ent_data_t              rd_data_i,
  input  logic [REG_W-1:ACC_G+1] acc_spare_i,
  output logic [REG_W-1:0]       acc_ld_o
);
  always_comb begin
    new_hi_o.vpn = vpn_i;
    new_hi_o.g   = acc_bits_i[ACC_G];
    new_hi_o.vld = (vpn_i < VLD_LIMIT);
    new_data_o   = ent_data_t'(acc_bits_i[ACC_DATA_W-1:0]);
  end

  // spare bits survive a load; G comes back from the tag
  assign acc_ld_o = {acc_spare_i, rd_hi_i.g, rd_data_i};
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_maint_pkg::*;
#(
  parameter  int unsigned WAYS  = 4,
  parameter  int unsigned SETS  = 16,
  parameter  int unsigned PID_W = 8,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [SET_W-1:0] set_i,
  input  ent_hi_t          wr_hi_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  ent_data_t        wr_data_i,
  input  logic [WAY_W-1:0] rd_way_i,
  output ent_hi_t          rd_hi_o,
  output logic [PID_W-1:0] rd_pid_o,
  output ent_data_t        rd_data_o
);
  ent_hi_t          way_hi   [WAYS];
  logic [PID_W-1:0] way_pid  [WAYS];
  ent_data_t        way_data [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ent_hi_t          hi_q   [SETS];
    logic [PID_W-1:0] pid_q  [SETS];
    ent_data_t        data_q [SETS];
    logic             sel_w;

    assign sel_w = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) begin
          hi_q[s]   <= '0;
          pid_q[s]  <= '0;
          data_q[s] <= '0;
        end
      end else if (sel_w) begin
        hi_q[set_i]   <= wr_hi_i;
        pid_q[set_i]  <= wr_pid_i;
        data_q[set_i] <= wr_data_i;
      end
    end

    assign way_hi[w]   = hi_q[set_i];
    assign way_pid[w]  = pid_q[set_i];
    assign way_data[w] = data_q[set_i];
  end

  assign rd_hi_o   = way_hi[rd_way_i];
  assign rd_pid_o  = way_pid[rd_way_i];
  assign rd_data_o = way_data[rd_way_i];
endmodule

// File: rtl/tlb_maint_regs.sv
module tlb_maint_regs
  import tlb_maint_pkg::*;
#(
  parameter int unsigned      WAYS      = 4,
  parameter int unsigned      SETS      = 16,
  parameter int unsigned      PID_W     = 8,
  parameter logic [VPN_W-1:0] VLD_LIMIT = 20'hC0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             pid_chg_o,
  output logic [PID_W-1:0] pid_old_o
);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned SET_W = $clog2(SETS);

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  // read-back views
  logic [REG_W-1:0] acc_rb_q, ctl_rb_q, pte_rb_q;
  // written views (only the fields entry operations use)
  logic [PID_W-1:0] pid_wr_q;
  logic [VPN_W-1:0] vpn_wr_q;
  logic             pid_chg_q;
  logic [PID_W-1:0] pid_old_q;

  logic acc_wr, ctl_wr, pte_wr, ent_st, ent_ld, pid_diff;
  assign acc_wr   = we_i && (sel == SEL_ACC);
  assign ctl_wr   = we_i && (sel == SEL_CTL);
  assign pte_wr   = we_i && (sel == SEL_PTE);
  assign ent_st   = acc_wr && ctl_rb_q[CTL_WE];
  assign ent_ld   = ctl_wr && wdata_i[CTL_RD];
  assign pid_diff = wdata_i[CTL_PID_LSB +: PID_W] != pid_wr_q;

  logic [WAY_W-1:0] st_way, st_way_nxt, ld_way;
  logic [SET_W-1:0] set_idx;
  assign st_way     = ctl_rb_q[CTL_WAY_LSB +: WAY_W];
  assign st_way_nxt = WAY_W'(st_way + 1'b1);
  assign ld_way     = wdata_i[CTL_WAY_LSB +: WAY_W];
  assign set_idx    = vpn_wr_q[SET_W-1:0];

  ent_hi_t          new_hi, rd_hi;
  ent_data_t        new_data, rd_data;
  logic [PID_W-1:0] rd_pid;
  logic [REG_W-1:0] acc_ld;

  tlb_entry_codec #(
    .VLD_LIMIT(VLD_LIMIT)
  ) u_codec (
    .acc_bits_i (wdata_i[ACC_G:0]),
    .vpn_i      (vpn_wr_q),
    .new_hi_o   (new_hi),
    .new_data_o (new_data),
    .rd_hi_i    (rd_hi),
    .rd_data_i  (rd_data),
    .acc_spare_i(acc_rb_q[REG_W-1:ACC_G+1]),
    .acc_ld_o   (acc_ld)
  );

  tlb_entry_store #(
    .WAYS (WAYS),
    .SETS (SETS),
    .PID_W(PID_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (ent_st),
    .wr_way_i (st_way),
    .set_i    (set_idx),
    .wr_hi_i  (new_hi),
    .wr_pid_i (pid_wr_q),
    .wr_data_i(new_data),
    .rd_way_i (ld_way),
    .rd_hi_o  (rd_hi),
    .rd_pid_o (rd_pid),
    .rd_data_o(rd_data)
  );

  logic [REG_W-1:0] ctl_nxt, pte_nxt;
  always_comb begin
    ctl_nxt = wdata_i;
    if (ent_ld) begin
      ctl_nxt[CTL_PID_LSB +: PID_W] = rd_pid;
      ctl_nxt[CTL_VLD]              = rd_hi.vld;
    end
    pte_nxt = wdata_i;
    pte_nxt[PTE_VPN_LSB +: VPN_W] = pte_rb_q[PTE_VPN_LSB +: VPN_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_rb_q  <= '0;
      ctl_rb_q  <= '0;
      pte_rb_q  <= '0;
      pid_wr_q  <= '0;
      vpn_wr_q  <= '0;
      pid_chg_q <= 1'b0;
      pid_old_q <= '0;
    end else begin
      pid_chg_q <= 1'b0;
      if (ent_st) begin
        ctl_rb_q[CTL_WAY_LSB +: CTL_WAY_FW] <= CTL_WAY_FW'(st_way_nxt);
      end
      if (ctl_wr) begin
        ctl_rb_q <= ctl_nxt;
        pid_wr_q <= wdata_i[CTL_PID_LSB +: PID_W];
        if (pid_diff) begin
          pid_chg_q <= 1'b1;
          pid_old_q <= pid_wr_q;
        end
        if (ent_ld) begin
          acc_rb_q                      <= acc_ld;
          pte_rb_q[PTE_VPN_LSB +: VPN_W] <= rd_hi.vpn;
        end
      end
      if (pte_wr) begin
        pte_rb_q <= pte_nxt;
        vpn_wr_q <= wdata_i[PTE_VPN_LSB +: VPN_W];
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ACC: rdata_o = acc_rb_q;
      SEL_CTL: rdata_o = ctl_rb_q;
      SEL_PTE: rdata_o = pte_rb_q;
      default: rdata_o = '0;
    endcase
  end

  assign pid_chg_o = pid_chg_q;
  assign pid_old_o = pid_old_q;

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |=> (acc_rb_q == $past(acc_rb_q)));

  // R6
  way_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_st |=> (ctl_rb_q[CTL_WAY_LSB +: CTL_WAY_FW] ==
                CTL_WAY_FW'(WAY_W'($past(st_way) + 1'b1))));

  // R9
  pte_vpn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pte_wr |=> (pte_rb_q[PTE_VPN_LSB +: VPN_W] == $past(pte_rb_q[PTE_VPN_LSB +: VPN_W])));

  // R10
  pid_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && pid_diff) |=> (pid_chg_o && (pid_old_o == $past(pid_wr_q))));

  // R10
  pid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_wr && pid_diff) |=> !pid_chg_o);

  // R11
  ctl_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !wdata_i[CTL_RD]) |=> (ctl_rb_q == $past(wdata_i)));
endmodule

// File: tb/tlb_maint_regs_tb_top.sv
`timescale 1ns/1ps
module tlb_maint_regs_tb_top;
  localparam int NW = 4;
  localparam int NS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel_i = 2'd3;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pid_chg_o;
  logic [7:0]  pid_old_o;

  always #4 clk_i = ~clk_i;

  tlb_maint_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pid_chg_o(pid_chg_o),
    .pid_old_o(pid_old_o)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [31:0] m_acc = '0, m_ctl = '0, m_pte = '0, m_ptew = '0, m_ctlw = '0;
  logic [19:0] m_vpn [NW][NS];
  logic [7:0]  m_pid [NW][NS];
  logic [23:0] m_dat [NW][NS];
  logic        m_g   [NW][NS];
  logic        m_vld [NW][NS];

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_chg, input logic [7:0] exp_old);
    sel_i = 2'd0; #0.5; chk(req, "acc", rdata_o, m_acc);
    sel_i = 2'd1; #0.5; chk(req, "ctl", rdata_o, m_ctl);
    sel_i = 2'd2; #0.5; chk(req, "pte", rdata_o, m_pte);
    chk(req, "pid_chg", {31'd0, pid_chg_o}, {31'd0, exp_chg});
    if (exp_chg) chk(req, "pid_old", {24'd0, pid_old_o}, {24'd0, exp_old});
  endtask

  task automatic op(input int s, input logic [31:0] v, input string req);
    logic       e_chg;
    logic [7:0] e_old;
    int         w, st;
    logic [19:0] vpn;
    @(negedge clk_i);
    sel_i = 2'(s); we_i = 1'b1; wdata_i = v;
    @(posedge clk_i);
    #1;
    we_i = 1'b0;
    e_chg = 1'b0; e_old = '0;
    vpn = m_ptew[21:2];
    st  = int'(vpn) % NS;
    if (s == 0) begin
      if (m_ctl[1]) begin
        w = int'(m_ctl[31:28]) % NW;
        m_vpn[w][st] = vpn;
        m_g[w][st]   = v[24];
        m_vld[w][st] = (vpn < 20'hC0000);
        m_pid[w][st] = m_ctlw[9:2];
        m_dat[w][st] = v[23:0];
        m_ctl[31:28] = 4'((w + 1) % NW);
      end
    end else if (s == 1) begin
      if (v[9:2] != m_ctlw[9:2]) begin
        e_chg = 1'b1; e_old = m_ctlw[9:2];
      end
      m_ctl = v;
      if (v[0]) begin
        w = int'(v[31:28]) % NW;
        m_acc = {m_acc[31:25], m_g[w][st], m_dat[w][st]};
        m_ctl[9:2]  = m_pid[w][st];
        m_ctl[10]   = m_vld[w][st];
        m_pte[21:2] = m_vpn[w][st];
      end
      m_ctlw = v;
    end else if (s == 2) begin
      m_pte  = {v[31:22], m_pte[21:2], v[1:0]};
      m_ptew = v;
    end
    check_all(req, e_chg, e_old);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R1 watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin
        m_vpn[w][s] = '0; m_pid[w][s] = '0; m_dat[w][s] = '0;
        m_g[w][s] = 1'b0; m_vld[w][s] = 1'b0;
      end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1", 1'b0, 8'd0);
    op(1, 32'h2000_0001, "R1");                          // load empty entry
    op(2, 32'hABC0_0000 | (32'h12345 << 2) | 32'h3, "R9");
    op(1, 32'h1000_0000 | (32'h5A << 2) | 32'h2, "R10"); // PID 0 -> 5A
    op(0, 32'hFFF0_ABCD, "R5");                          // store way1, spare bits dropped
    op(0, 32'h00A0_1234, "R6");                          // way2
    op(0, 32'h0030_0001, "R6");                          // way3, wraps to 0
    op(2, 32'h0000_0000 | (32'hC0005 << 2), "R4");
    op(0, 32'h0110_0777, "R4");                          // invalid entry way0
    op(1, 32'h1000_0000 | (32'h33 << 2) | 32'h1, "R8");  // load way1 set5
    op(1, 32'h0000_0000 | (32'h33 << 2) | 32'h1, "R4");  // load invalid way0
    op(0, 32'h0055_5555, "R2");                          // store disabled
    op(1, 32'h0000_0000 | (32'h33 << 2) | 32'h1, "R2");
    op(1, 32'h0000_0000 | (32'h33 << 2) | 32'h2, "R11"); // same PID, no event
    op(2, 32'h0040_0000 | (32'h00015 << 2), "R9");
    op(0, 32'h0020_0042, "R3");                          // uses written VPN and PID
    op(1, 32'h0000_0000 | (32'h77 << 2) | 32'h1, "R8");
    op(1, 32'h0000_0000 | (32'h77 << 2) | 32'h3, "R7");
    op(0, 32'hFFFF_FFFF, "R7");
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int s;
      logic [31:0] v;
      seed = seed * 32'd1103515245 + 32'd12345;
      s = int'(seed[17:16]) % 3;
      v = {seed[31:16], seed[15:0] ^ seed[31:16]};
      if (s == 1) begin
        v[9:2] = (seed[20]) ? 8'h5A : 8'h33;
        v[1]   = seed[21] | seed[22];
      end
      if (s == 2 && seed[23]) v[21:2] = {2'b11, 14'd0, v[5:2]};
      op(s, v, "R3");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule